// File: doc/BRIEF.md
# Configurable Audio Frame Serializer

This block turns parallel audio samples into a serial data bit stream plus a frame-sync (word-select) line, advancing one bit per bit-clock strobe. One engine produces four framings: classic two-half I2S with its one-bit data lag, left-justified, PCM with a one-bit sync pulse, and PCM with a sync pulse one slot wide. With more than two slots it works as a TDM transmitter.

Samples arrive on a valid/ready stream and are requested one slot before they are needed. Per-slot masks decide which slots carry sound and which slots are passed over without drawing from the stream. A mono option plays one sample on both halves of a two-slot frame. The sample width may be shorter than the slot, and the bit order can be selected. Configuration is taken only at the first bit of each frame, and `en` low stops and clears the transmitter.

Top module: `i2s_tdm_tx`

## Requirements
- R1: After reset, and one clock after `en` is low, `sd` is 0 and `s_ready` is 0. While stopped, `ws` rests at 1 when `cfg_slots` > 2 and `cfg_fmt` is 0 or 1, and at 0 otherwise. `underflow` is 0 after reset.
- R2: For `cfg_fmt` 0 (I2S) and 1 (left-justified), frame bit position p < slots*width/2 drives `ws` low when `cfg_slots` is 2, and high when `cfg_slots` > 2. The second half of the frame drives the opposite level.
- R3: For `cfg_fmt` 2 (PCM short sync), `ws` is high only at frame bit position 0.
- R4: For `cfg_fmt` 3 (PCM long sync), `ws` is high for the first `cfg_width` bit positions of the frame.
- R5: For `cfg_fmt` 0, each data bit appears one bit position after the position it belongs to, so it trails the `ws` edge by one bit. For every other format, the first bit of a slot coincides with the slot's first position.
- R6: Within a slot, bit k (k < `cfg_sbits`) is sample bit `cfg_sbits`-1-k when `cfg_msb` is 1, and sample bit k when it is 0. Positions k >= `cfg_sbits` send 0. Samples are right-aligned on `s_data`.
- R7: A slot whose bit in `cfg_act` (bit n = slot n) is 0 sends zeros but still draws and discards one sample.
- R8: A slot whose bit in `cfg_skip` is 1 sends zeros and draws no sample. Skip takes precedence over `cfg_act`.
- R9: With `cfg_mono` = 1 and `cfg_slots` = 2, slot 1 repeats the sample taken for slot 0, and only one sample is drawn per frame.
- R10: `s_ready` rises at the start of the slot before a sample-drawing slot and falls after a transfer. A transfer in the clock of the slot start is used by that slot. A drawing slot that finds no sample sends zeros and sets `underflow`, which stays 1 until reset.
- R11: Format, counts, widths, masks, mono and bit order are captured at the first bit of each frame. Changes made mid-frame take effect at the next frame.
- R12: `sd` and `ws` change only in the clock after a `bclk_stb` pulse, or after `en` falls.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low stops and clears the transmitter |
| bclk_stb | input | 1 | One-clock strobe per serial bit |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_data | input | WID_MAX | Sample, right-aligned |
| cfg_fmt | input | 2 | 0 I2S, 1 left-justified, 2 PCM short, 3 PCM long |
| cfg_slots | input | $clog2(SLOT_MAX+1) | Slots per frame, 2..SLOT_MAX |
| cfg_width | input | $clog2(WID_MAX+1) | Bits per slot |
| cfg_sbits | input | $clog2(WID_MAX+1) | Valid sample bits, 1..cfg_width |
| cfg_act | input | SLOT_MAX | Active slot mask |
| cfg_skip | input | SLOT_MAX | Slots passed over without drawing a sample |
| cfg_mono | input | 1 | Mono duplication for two-slot frames |
| cfg_msb | input | 1 | 1 = MSB first, 0 = LSB first |
| sd | output | 1 | Serial data |
| ws | output | 1 | Word select / frame sync |
| underflow | output | 1 | Sticky missing-sample flag |

## Verification
Each framing is run with its own slot count, slot width and sample width: 2x16 I2S, 4x8 left-justified, PCM short with LSB-first 6-bit samples, and PCM long with 3 slots of 10. This separates the half-frame, one-bit and one-slot sync widths, and the one-bit data lag from its absence. Separate runs with an active mask, with a skip mask and with mono show which slots draw a sample from the stream, because a wrong draw shifts every later sample. A mid-frame configuration change checks that capture waits for the frame boundary. A starved stream checks the zero fill and the sticky flag.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;
  typedef enum logic [1:0] {
    FMT_STD       = 2'd0,
    FMT_LEFT      = 2'd1,
    FMT_PCM_SHORT = 2'd2,
    FMT_PCM_LONG  = 2'd3
  } frame_fmt_e;
endpackage

// File: rtl/i2stx_ws_gen.sv
module i2stx_ws_gen
  import i2stx_pkg::*;
#(
  parameter int P_W    = 9,
  parameter int WID_CW = 6
) (
  input  frame_fmt_e        fmt,
  input  logic [P_W-1:0]    pos,
  input  logic [P_W-1:0]    half,
  input  logic [WID_CW-1:0] width,
  input  logic              idle_hi,
  output logic              ws
);
  always_comb begin
    unique case (fmt)
      FMT_PCM_SHORT: ws = (pos == '0);
      FMT_PCM_LONG:  ws = (pos < P_W'(width));
      default:       ws = (pos < half) ? idle_hi : ~idle_hi;
    endcase
  end
endmodule

// File: rtl/i2stx_bit_pick.sv
module i2stx_bit_pick #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [W-1:0]  word,
  input  logic [CW-1:0] idx,
  input  logic [CW-1:0] sbits,
  input  logic          msb_first,
  input  logic          en,
  output logic          bit_o
);
  logic [CW-1:0] sel;
  logic [W-1:0]  sh;

  always_comb begin
    sel   = '0;
    sh    = '0;
    bit_o = 1'b0;
    if (en && (idx < sbits)) begin
      sel   = msb_first ? (sbits - CW'(1) - idx) : idx;
      sh    = word >> sel;
      bit_o = sh[0];
    end
  end
endmodule

// File: rtl/i2s_tdm_tx.sv
module i2s_tdm_tx
  import i2stx_pkg::*;
#(
  parameter int SLOT_MAX = 8,
  parameter int WID_MAX  = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              en,
  input  logic                              bclk_stb,
  input  logic                              s_valid,
  output logic                              s_ready,
  input  logic [WID_MAX-1:0]                s_data,
  input  logic [1:0]                        cfg_fmt,
  input  logic [$clog2(SLOT_MAX+1)-1:0]     cfg_slots,
  input  logic [$clog2(WID_MAX+1)-1:0]      cfg_width,
  input  logic [$clog2(WID_MAX+1)-1:0]      cfg_sbits,
  input  logic [SLOT_MAX-1:0]               cfg_act,
  input  logic [SLOT_MAX-1:0]               cfg_skip,
  input  logic                              cfg_mono,
  input  logic                              cfg_msb,
  output logic                              sd,
  output logic                              ws,
  output logic                              underflow
);
  localparam int SLOT_CW = $clog2(SLOT_MAX + 1);
  localparam int WID_CW  = $clog2(WID_MAX + 1);
  localparam int P_W     = $clog2(SLOT_MAX * WID_MAX + 1);

  typedef struct packed {
    frame_fmt_e          fmt;
    logic [SLOT_CW-1:0]  slots;
    logic [WID_CW-1:0]   width;
    logic [WID_CW-1:0]   sbits;
    logic [SLOT_MAX-1:0] act;
    logic [SLOT_MAX-1:0] skip;
    logic                mono;
    logic                msb;
  } cfg_t;

  cfg_t cfg_in, cfg_q, cfg_now;
  logic [SLOT_CW-1:0] slot_q, slot_nx;
  logic [WID_CW-1:0]  bit_q;
  logic [P_W-1:0]     pos_q, half;
  logic started_q, want_q, nxt_ok_q;
  logic [WID_MAX-1:0] nxt_q, cur_q, word_now, fdata;
  logic prev_raw_q, sd_q, ws_q, uf_q;
  logic last_bit, last_slot, skip_cur, cons_cur, cons_next, fresh, bit_en;
  logic raw, ws_c, idle_stop;

  function automatic logic mask_bit(input logic [SLOT_MAX-1:0] m, input logic [SLOT_CW-1:0] i);
    return |(m & (SLOT_MAX'(1) << i));
  endfunction

  always_comb begin
    cfg_in.fmt   = frame_fmt_e'(cfg_fmt);
    cfg_in.slots = cfg_slots;
    cfg_in.width = cfg_width;
    cfg_in.sbits = cfg_sbits;
    cfg_in.act   = cfg_act;
    cfg_in.skip  = cfg_skip;
    cfg_in.mono  = cfg_mono;
    cfg_in.msb   = cfg_msb;
  end

  // at a frame boundary the live settings apply; otherwise the captured ones
  assign cfg_now   = (pos_q == '0) ? cfg_in : cfg_q;
  assign last_bit  = (bit_q == cfg_now.width - WID_CW'(1));
  assign last_slot = (slot_q == cfg_now.slots - SLOT_CW'(1));
  assign slot_nx   = last_slot ? '0 : slot_q + SLOT_CW'(1);
  assign skip_cur  = mask_bit(cfg_now.skip, slot_q);
  assign cons_cur  = !skip_cur &&
                     !(cfg_now.mono && cfg_now.slots == SLOT_CW'(2) && slot_q == SLOT_CW'(1));
  assign cons_next = !mask_bit(cfg_now.skip, slot_nx) &&
                     !(cfg_now.mono && cfg_now.slots == SLOT_CW'(2) && slot_nx == SLOT_CW'(1));
  assign fresh     = nxt_ok_q | (want_q & s_valid);
  assign fdata     = nxt_ok_q ? nxt_q : s_data;
  assign bit_en    = mask_bit(cfg_now.act, slot_q) & ~skip_cur;
  assign half      = (P_W'(cfg_now.slots) * P_W'(cfg_now.width)) >> 1;
  assign idle_stop = (cfg_in.slots > SLOT_CW'(2)) &&
                     (cfg_in.fmt == FMT_STD || cfg_in.fmt == FMT_LEFT);

  always_comb begin
    if (bit_q != '0)   word_now = cur_q;
    else if (cons_cur) word_now = fresh ? fdata : '0;
    else if (skip_cur) word_now = '0;
    else               word_now = cur_q;
  end

  i2stx_bit_pick #(.W(WID_MAX), .CW(WID_CW)) u_pick (
    .word(word_now), .idx(bit_q), .sbits(cfg_now.sbits),
    .msb_first(cfg_now.msb), .en(bit_en), .bit_o(raw)
  );

  i2stx_ws_gen #(.P_W(P_W), .WID_CW(WID_CW)) u_wsg (
    .fmt(cfg_now.fmt), .pos(pos_q), .half(half), .width(cfg_now.width),
    .idle_hi(cfg_now.slots > SLOT_CW'(2)), .ws(ws_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0; slot_q <= '0; bit_q <= '0; pos_q <= '0;
      started_q <= 1'b0; want_q <= 1'b0; nxt_ok_q <= 1'b0;
      nxt_q <= '0; cur_q <= '0; prev_raw_q <= 1'b0;
      sd_q <= 1'b0; ws_q <= 1'b0; uf_q <= 1'b0;
    end else if (!en) begin
      slot_q <= '0; bit_q <= '0; pos_q <= '0;
      started_q <= 1'b0; want_q <= 1'b0; nxt_ok_q <= 1'b0;
      cur_q <= '0; prev_raw_q <= 1'b0;
      sd_q <= 1'b0; ws_q <= idle_stop;
    end else begin
      // request the first slot's sample before the first strobe
      if (!started_q && !want_q && !nxt_ok_q) want_q <= cons_cur;
      if (want_q && s_valid) begin
        nxt_q    <= s_data;
        nxt_ok_q <= 1'b1;
        want_q   <= 1'b0;
      end
      if (bclk_stb) begin
        started_q  <= 1'b1;
        if (pos_q == '0) cfg_q <= cfg_in;
        sd_q       <= (cfg_now.fmt == FMT_STD) ? prev_raw_q : raw;
        prev_raw_q <= raw;
        ws_q       <= ws_c;
        if (last_bit) begin
          bit_q <= '0;
          if (last_slot) begin
            slot_q <= '0;
            pos_q  <= '0;
          end else begin
            slot_q <= slot_nx;
            pos_q  <= pos_q + P_W'(1);
          end
        end else begin
          bit_q <= bit_q + WID_CW'(1);
          pos_q <= pos_q + P_W'(1);
        end
        if (bit_q == '0) begin
          cur_q  <= word_now;
          want_q <= cons_next;
          if (cons_cur) begin
            nxt_ok_q <= 1'b0;
            if (!fresh) uf_q <= 1'b1;
          end
        end
      end
    end
  end

  assign s_ready   = want_q;
  assign sd        = sd_q;
  assign ws        = ws_q;
  assign underflow = uf_q;

  // R1: stopping clears the line and the request
  a_r1_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!s_ready && !sd));
  // R10: underflow is sticky
  a_r10_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);
  // R10: a transfer outside a slot start withdraws the request
  a_r10_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (s_ready && s_valid && !(bclk_stb && bit_q == '0)) |=> !s_ready);
  // R12: line outputs move only on bit strobes
  a_r12_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
    (en && !bclk_stb) |=> ($stable(sd) && $stable(ws)));
endmodule

// File: tb/i2s_tdm_tx_tb.sv
module i2s_tdm_tx_tb;
  localparam int SM = 8;
  localparam int WM = 32;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, bclk_stb = 1'b0, s_valid = 1'b0;
  logic [WM-1:0] s_data = '0;
  logic [1:0] cfg_fmt = 2'd0;
  logic [3:0] cfg_slots = 4'd2;
  logic [5:0] cfg_width = 6'd16, cfg_sbits = 6'd16;
  logic [SM-1:0] cfg_act = '1, cfg_skip = '0;
  logic cfg_mono = 1'b0, cfg_msb = 1'b1;
  logic s_ready, sd, ws, underflow;

  i2s_tdm_tx #(.SLOT_MAX(SM), .WID_MAX(WM)) u_dut (
    .clk(clk), .rst(rst), .en(en), .bclk_stb(bclk_stb), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .cfg_fmt(cfg_fmt), .cfg_slots(cfg_slots),
    .cfg_width(cfg_width), .cfg_sbits(cfg_sbits), .cfg_act(cfg_act),
    .cfg_skip(cfg_skip), .cfg_mono(cfg_mono), .cfg_msb(cfg_msb),
    .sd(sd), .ws(ws), .underflow(underflow)
  );

  always #2 clk = ~clk;

  int vectors = 0, fails = 0, stb_cnt = 0;
  bit supply_on = 1'b0, done = 1'b0;
  string cur_req = "R1";
  logic [31:0] src_q[$], acc_q[$];
  logic [31:0] lcg = 32'h1234_5678;

  // model state
  int ms, mk, mp, mfmt, mslots, mwid, msbn;
  logic [SM-1:0] mact, mskip;
  bit mmono, mmsb;
  logic [31:0] word;
  logic prev_raw, e_sd = 1'b0, e_ws = 1'b0, e_uf = 1'b0;

  // strobe and stream source, driven 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (!en) begin
      stb_cnt  = 0;
      bclk_stb = 1'b0;
    end else begin
      bclk_stb = (stb_cnt == 3);
      stb_cnt  = (stb_cnt == 3) ? 0 : stb_cnt + 1;
    end
    s_valid = supply_on && (src_q.size() != 0);
    s_data  = s_valid ? src_q[0] : '0;
  end

  // behavioural reference
  always @(posedge clk) begin
    logic r;
    int half;
    if (rst) begin
      ms = 0; mk = 0; mp = 0; prev_raw = 0; word = 0;
      e_sd = 0; e_ws = 0; e_uf = 0; acc_q.delete();
    end else if (!en) begin
      ms = 0; mk = 0; mp = 0; prev_raw = 0; word = 0; acc_q.delete();
      e_sd = 0;
      e_ws = (cfg_slots > 2) && (cfg_fmt < 2);
    end else begin
      if (s_valid && s_ready) begin
        acc_q.push_back(s_data);
        void'(src_q.pop_front());
      end
      if (bclk_stb) begin
        if (mp == 0) begin
          mfmt = cfg_fmt; mslots = cfg_slots; mwid = cfg_width; msbn = cfg_sbits;
          mact = cfg_act; mskip = cfg_skip; mmono = cfg_mono; mmsb = cfg_msb;
        end
        if (mk == 0) begin
          if (mskip[ms]) word = 0;
          else if (!(mmono && mslots == 2 && ms == 1)) begin
            if (acc_q.size() != 0) word = acc_q.pop_front();
            else begin word = 0; e_uf = 1; end
          end
        end
        r = 1'b0;
        if (mact[ms] && !mskip[ms] && mk < msbn) r = mmsb ? word[msbn-1-mk] : word[mk];
        e_sd = (mfmt == 0) ? prev_raw : r;
        prev_raw = r;
        half = (mslots * mwid) / 2;
        case (mfmt)
          2: e_ws = (mp == 0);
          3: e_ws = (mp < mwid);
          default: e_ws = (mp < half) ? (mslots > 2) : !(mslots > 2);
        endcase
        mp++; mk++;
        if (mk == mwid) begin
          mk = 0; ms++;
          if (ms == mslots) begin ms = 0; mp = 0; end
        end
      end
    end
  end

  // per-clock comparison, R12 timing covered by every vector
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (sd !== e_sd || ws !== e_ws || underflow !== e_uf) begin
        fails++;
        $display("FAIL %s/R12 t=%0t sd/ws/uf actual %b%b%b expected %b%b%b",
                 cur_req, $time, sd, ws, underflow, e_sd, e_ws, e_uf);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input string req, input int fmt, input int slots, input int wid,
                       input int sb, input logic [SM-1:0] act, input logic [SM-1:0] skp,
                       input bit mono, input bit msb, input bit supply);
    @(negedge clk);
    en = 0;
    cur_req = req;
    cfg_fmt = 2'(fmt); cfg_slots = 4'(slots); cfg_width = 6'(wid); cfg_sbits = 6'(sb);
    cfg_act = act; cfg_skip = skp; cfg_mono = mono; cfg_msb = msb;
    src_q.delete();
    for (int i = 0; i < 64; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      src_q.push_back(lcg);
    end
    supply_on = supply;
    repeat (3) @(negedge clk);
    en = 1;
  endtask

  task automatic run_frames(input int n, input int slots, input int wid);
    repeat (n * slots * wid * 4 + 6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(s_ready === 1'b0 && sd === 1'b0 && underflow === 1'b0, "R1 reset state", sd, 0);
    cfg_slots = 4'd4;
    repeat (2) @(negedge clk);
    check(ws === 1'b1, "R1 idle ws for four slots", ws, 1);

    setup("R2 R5 R6 I2S", 0, 2, 16, 16, '1, '0, 0, 1, 1);
    run_frames(3, 2, 16);
    setup("R2 R5 left-justified", 1, 4, 8, 8, '1, '0, 0, 1, 1);
    run_frames(3, 4, 8);
    setup("R3 R6 PCM short LSB", 2, 4, 8, 6, '1, '0, 0, 0, 1);
    run_frames(3, 4, 8);
    setup("R4 PCM long", 3, 3, 10, 10, '1, '0, 0, 1, 1);
    run_frames(3, 3, 10);
    setup("R7 active mask", 1, 4, 8, 8, 8'b0000_0101, '0, 0, 1, 1);
    run_frames(3, 4, 8);
    setup("R8 skip mask", 2, 4, 8, 8, '1, 8'b0000_0010, 0, 1, 1);
    run_frames(3, 4, 8);
    setup("R9 mono", 0, 2, 12, 10, '1, '0, 1, 1, 1);
    run_frames(3, 2, 12);

    setup("R11 mid-frame change", 0, 2, 16, 16, '1, '0, 0, 1, 1);
    repeat (60) @(negedge clk);
    cfg_fmt = 2'd3; cfg_slots = 4'd4; cfg_width = 6'd8; cfg_sbits = 6'd5; cfg_msb = 1'b0;
    run_frames(3, 4, 8);
    check(underflow === 1'b0, "R10 no underflow with a supplied stream", underflow, 0);
    check(src_q.size() < 64, "R10 stream drawn", src_q.size(), 63);

    setup("R10 starved stream", 1, 2, 8, 8, '1, '0, 0, 1, 0);
    repeat (3) @(negedge clk);
    check(s_ready === 1'b1, "R10 ready raised before first slot", s_ready, 1);
    run_frames(1, 2, 8);
    check(underflow === 1'b1, "R10 underflow set", underflow, 1);
    @(negedge clk);
    en = 0;
    repeat (2) @(negedge clk);
    check(underflow === 1'b1 && s_ready === 1'b0, "R10 R1 sticky after stop", underflow, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule